// File: doc/BRIEF.md
# Digital PLL Holdover State Controller

This block follows the operating state of a digital phase-locked loop and decides which frequency tuning word drives the loop's oscillator. It has four states: free-run, lock acquisition, locked and holdover. In free-run the oscillator is driven by a nominal numerator plus a signed 40-bit offset. In acquisition and locked the loop's own live tuning word passes through. In holdover a word that was captured on entry is held. The captured word comes from the averaged tuning history when history is enabled and that history is valid. Otherwise it comes from the nominal value plus the free-run offset.

The state transitions are these:
- Free-run goes to acquisition when a valid reference becomes available.
- Acquisition goes to locked once the raw phase-lock indication has stayed true for LOCK_QUAL consecutive cycles.
- Locked drops back to acquisition when phase lock is lost or the reference is switched.
- Acquisition or locked goes to holdover when the reference is lost and no other valid reference exists.
- Holdover goes back to acquisition as soon as a valid reference appears. On that exit cycle the held word is offered to the loop as its starting value, so that the output frequency does not step.

The block also produces two status flags, loss of phase lock and loss of frequency lock. The frequency-lock flag is frozen while in free-run or holdover.

Top module: `dpll_hold_ctrl`

## Requirements
- R1: After reset the state is free-run (code 0), both loss flags read 1, the source flag reads 0, and the tuning word equals NOMINAL + free_word_i (two's-complement, wrapping modulo 2^40).
- R2: State codes are free-run 0, acquisition 1, locked 2 and holdover 3. Free-run moves to acquisition at the first clock edge that sees ref_avail_i = 1.
- R3: Acquisition moves to locked at the edge that completes LOCK_QUAL consecutive acquisition cycles with raw_plock_i = 1 and ref_lost_i = 0. A cycle with raw_plock_i = 0 or ref_lost_i = 1 restarts the count.
- R4: In acquisition or locked, ref_lost_i = 1 with ref_avail_i = 0 gives holdover at the next edge. ref_lost_i = 1 with ref_avail_i = 1 gives acquisition at the next edge.
- R5: At holdover entry the held word is latched. It is hist_word_i when hist_en_i = 1 and hist_valid_i = 1, and NOMINAL + free_word_i otherwise. hold_from_hist_o latches 1 for the history source and 0 for the free-run source.
- R6: While in holdover, the tuning word does not change when hist_valid_i, hist_word_i, free_word_i or loop_word_i change.
- R7: phase_unlock_o is 0 in the locked state and 1 in every other state.
- R8: freq_unlock_o takes the inverse of raw_flock_i at each edge whose next state is acquisition or locked. At every other edge it keeps its value, so it stays frozen through free-run and holdover.
- R9: In holdover with ref_avail_i = 1, loop_preset_o is 1 and the tuning word is the held word. The next state is acquisition. loop_preset_o is 0 at all other times.
- R10: In acquisition and locked the tuning word equals loop_word_i.
- R11: Locked moves to acquisition at the next edge when raw_plock_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_lost_i | input | 1 | Loss of the current reference detected |
| ref_avail_i | input | 1 | A valid reference is available for selection |
| hist_en_i | input | 1 | Enable use of the tuning history in holdover |
| hist_valid_i | input | 1 | Averaged history word is valid |
| hist_word_i | input | TW_W | Averaged history tuning word |
| free_word_i | input | TW_W | Signed free-run offset from NOMINAL |
| loop_word_i | input | TW_W | Live tuning word from the loop filter |
| raw_plock_i | input | 1 | Raw phase-lock indication |
| raw_flock_i | input | 1 | Raw frequency-lock indication |
| state_o | output | 2 | Current state code |
| tune_word_o | output | TW_W | Selected oscillator tuning word |
| loop_preset_o | output | 1 | Load the tuning word into the loop as its starting value |
| hold_from_hist_o | output | 1 | Held word came from the history |
| phase_unlock_o | output | 1 | Loss of phase lock |
| freq_unlock_o | output | 1 | Loss of frequency lock |

## Verification
The bench builds the block with LOCK_QUAL = 5 and a nonzero NOMINAL. This makes a restarted qualification count visible within a few cycles, and it lets a negative free-run offset show up as a wrapped sum that differs from both the nominal value and the history word. Directed sequences cover every combination of history enable and history valid at holdover entry. They also cover an input change in the middle of holdover, a reference switch while locked, and holdover entered straight from acquisition. A long pseudo-random phase then drives all inputs against a behavioural model that is compared on every clock.

// File: rtl/dpll_hold_pkg.sv
package dpll_hold_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2,
        ST_HOLD = 2'd3
    } dpll_state_t;
endpackage

// File: rtl/dpll_lock_qual.sv
module dpll_lock_qual #(
    parameter int LOCK_QUAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_acq,
    input  logic restart,
    input  logic raw_plock,
    output logic qualified
);
    localparam int CW = $clog2(LOCK_QUAL + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_QUAL - 1);
    localparam logic [CW-1:0] TOP  = CW'(LOCK_QUAL);

    logic [CW-1:0] run_q;
    logic          counting;

    assign counting  = in_acq && raw_plock && !restart;
    assign qualified = counting && (run_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!counting) begin
            run_q <= '0;
        end else if (run_q != TOP) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R3: the run length never passes the qualification count
    p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= TOP);
endmodule

// File: rtl/dpll_state_fsm.sv
module dpll_state_fsm
    import dpll_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_lost,
    input  logic        ref_avail,
    input  logic        raw_plock,
    input  logic        raw_flock,
    input  logic        qualified,
    output dpll_state_t state_q,
    output logic        enter_hold,
    output logic        leave_hold,
    output logic        lopl_q,
    output logic        lofl_q
);
    dpll_state_t state_nx;
    logic        orphaned;

    assign orphaned = ref_lost && !ref_avail;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FREE: if (ref_avail) state_nx = ST_ACQ;
            ST_ACQ: begin
                if (orphaned)       state_nx = ST_HOLD;
                else if (ref_lost)  state_nx = ST_ACQ;
                else if (qualified) state_nx = ST_LOCK;
            end
            ST_LOCK: begin
                if (orphaned)                   state_nx = ST_HOLD;
                else if (ref_lost || !raw_plock) state_nx = ST_ACQ;
            end
            ST_HOLD: if (ref_avail) state_nx = ST_ACQ;
        endcase
    end

    assign enter_hold = (state_nx == ST_HOLD) && (state_q != ST_HOLD);
    assign leave_hold = (state_q == ST_HOLD) && ref_avail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lopl_q <= 1'b1;
            lofl_q <= 1'b1;
        end else begin
            lopl_q <= (state_nx != ST_LOCK);
            if (state_nx == ST_ACQ || state_nx == ST_LOCK) lofl_q <= !raw_flock;
        end
    end

    // R4: an orphaned reference in acquisition or locked leads to holdover
    p_hold_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ACQ || state_q == ST_LOCK) && ref_lost && !ref_avail)
        |=> state_q == ST_HOLD);
    // R3: locked is reached only through a qualified acquisition cycle
    p_lock_needs_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQ && !qualified) |=> state_q != ST_LOCK);
    // R7: phase-loss flag tracks the locked state
    p_lopl_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lopl_q == (state_q != ST_LOCK));
    // R8: frequency-loss flag frozen while holdover continues
    p_lofl_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q != ST_HOLD || $stable(lofl_q)));
    // R9: preset only on the way out of holdover
    p_preset_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        leave_hold |=> state_q == ST_ACQ);
endmodule

// File: rtl/dpll_hold_word.sv
module dpll_hold_word
    import dpll_hold_pkg::*;
#(
    parameter int              TW_W    = 40,
    parameter logic [TW_W-1:0] NOMINAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  dpll_state_t     state_q,
    input  logic            enter_hold,
    input  logic            hist_en,
    input  logic            hist_valid,
    input  logic [TW_W-1:0] hist_word,
    input  logic [TW_W-1:0] free_word,
    input  logic [TW_W-1:0] loop_word,
    output logic [TW_W-1:0] tune_word,
    output logic            from_hist
);
    logic [TW_W-1:0] free_tw;
    logic [TW_W-1:0] held_q;
    logic            use_hist;

    assign free_tw  = NOMINAL + free_word;
    assign use_hist = hist_en && hist_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q    <= '0;
            from_hist <= 1'b0;
        end else if (enter_hold) begin
            held_q    <= use_hist ? hist_word : free_tw;
            from_hist <= use_hist;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FREE:         tune_word = free_tw;
            ST_ACQ, ST_LOCK: tune_word = loop_word;
            ST_HOLD:         tune_word = held_q;
        endcase
    end

    // R6: the word is kept for as long as holdover lasts
    p_word_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q != ST_HOLD || $stable(tune_word)));
    // R5: a valid enabled history at entry selects the history source
    p_src_hist_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_hold && use_hist) |=> from_hist);
endmodule

// File: rtl/dpll_hold_ctrl.sv
module dpll_hold_ctrl
    import dpll_hold_pkg::*;
#(
    parameter int              TW_W      = 40,
    parameter int              LOCK_QUAL = 8,
    parameter logic [TW_W-1:0] NOMINAL   = TW_W'(64'h0000_0080_0000_0000)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_lost_i,
    input  logic            ref_avail_i,
    input  logic            hist_en_i,
    input  logic            hist_valid_i,
    input  logic [TW_W-1:0] hist_word_i,
    input  logic [TW_W-1:0] free_word_i,
    input  logic [TW_W-1:0] loop_word_i,
    input  logic            raw_plock_i,
    input  logic            raw_flock_i,
    output logic [1:0]      state_o,
    output logic [TW_W-1:0] tune_word_o,
    output logic            loop_preset_o,
    output logic            hold_from_hist_o,
    output logic            phase_unlock_o,
    output logic            freq_unlock_o
);
    dpll_state_t state_q;
    logic        qualified;
    logic        enter_hold;
    logic        leave_hold;

    dpll_lock_qual #(.LOCK_QUAL(LOCK_QUAL)) qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_acq    (state_q == ST_ACQ),
        .restart   (ref_lost_i),
        .raw_plock (raw_plock_i),
        .qualified (qualified)
    );

    dpll_state_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_lost   (ref_lost_i),
        .ref_avail  (ref_avail_i),
        .raw_plock  (raw_plock_i),
        .raw_flock  (raw_flock_i),
        .qualified  (qualified),
        .state_q    (state_q),
        .enter_hold (enter_hold),
        .leave_hold (leave_hold),
        .lopl_q     (phase_unlock_o),
        .lofl_q     (freq_unlock_o)
    );

    dpll_hold_word #(.TW_W(TW_W), .NOMINAL(NOMINAL)) word_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .enter_hold (enter_hold),
        .hist_en    (hist_en_i),
        .hist_valid (hist_valid_i),
        .hist_word  (hist_word_i),
        .free_word  (free_word_i),
        .loop_word  (loop_word_i),
        .tune_word  (tune_word_o),
        .from_hist  (hold_from_hist_o)
    );

    assign state_o       = state_q;
    assign loop_preset_o = leave_hold;
endmodule

// File: tb/dpll_hold_ctrl_tb.sv
module dpll_hold_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 40;
    localparam int LQ = 5;
    localparam logic [TW-1:0] NOM = 40'h12_3456_7890;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_lost = 0, ref_avail = 0, hist_en = 0, hist_valid = 0;
    logic [TW-1:0] hist_word = '0, free_word = '0, loop_word = '0;
    logic          plock = 0, flock = 0;
    logic [1:0]    state_o;
    logic [TW-1:0] tune_o;
    logic          preset_o, src_o, lopl_o, lofl_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural model state
    int            ms, mc;
    logic [TW-1:0] mh;
    logic          msrc, mlopl, mlofl;
    int            ns, nc;
    logic [TW-1:0] nh;
    logic          nsrc, nlopl, nlofl;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpll_hold_ctrl #(.TW_W(TW), .LOCK_QUAL(LQ), .NOMINAL(NOM)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_lost_i(ref_lost), .ref_avail_i(ref_avail),
        .hist_en_i(hist_en), .hist_valid_i(hist_valid), .hist_word_i(hist_word),
        .free_word_i(free_word), .loop_word_i(loop_word), .raw_plock_i(plock),
        .raw_flock_i(flock), .state_o(state_o), .tune_word_o(tune_o),
        .loop_preset_o(preset_o), .hold_from_hist_o(src_o),
        .phase_unlock_o(lopl_o), .freq_unlock_o(lofl_o)
    );

    task automatic chk(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        ms = 0; mc = 0; mh = '0; msrc = 0; mlopl = 1; mlofl = 1;
    endtask

    task automatic check_model();
        logic [TW-1:0] et;
        string tt;
        if (ms == 0)      begin et = NOM + free_word; tt = "R1 tune free-run"; end
        else if (ms == 3) begin et = mh;              tt = "R5 tune held";     end
        else              begin et = loop_word;       tt = "R10 tune live";    end
        chk("R2 state", TW'(state_o), TW'(ms));
        chk(tt, tune_o, et);
        chk("R9 preset", TW'(preset_o), TW'(ms == 3 && ref_avail));
        chk("R5 source", TW'(src_o), TW'(msrc));
        chk("R7 phase flag", TW'(lopl_o), TW'(mlopl));
        chk("R8 freq flag", TW'(lofl_o), TW'(mlofl));
    endtask

    task automatic model_next();
        bit orphan = ref_lost && !ref_avail;
        bit cnt_on = (ms == 1) && plock && !ref_lost;
        bit qual   = cnt_on && (mc == LQ - 1);
        case (ms)
            0: ns = ref_avail ? 1 : 0;
            1: ns = orphan ? 3 : (ref_lost ? 1 : (qual ? 2 : 1));
            2: ns = orphan ? 3 : ((ref_lost || !plock) ? 1 : 2);
            default: ns = ref_avail ? 1 : 3;
        endcase
        nc = cnt_on ? ((mc < LQ) ? mc + 1 : mc) : 0;
        nh = mh; nsrc = msrc;
        if (ns == 3 && ms != 3) begin
            nsrc = hist_en && hist_valid;
            nh   = nsrc ? hist_word : NOM + free_word;
        end
        nlopl = (ns != 2);
        nlofl = (ns == 1 || ns == 2) ? !flock : mlofl;
    endtask

    task automatic tick();
        #1;
        check_model();
        model_next();
        @(posedge clk);
        ms = ns; mc = nc; mh = nh; msrc = nsrc; mlopl = nlopl; mlofl = nlofl;
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            loop_word = loop_word + 40'h1_0001;
            tick();
        end
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lf;
        logic [TW-1:0] h1;
        model_reset();
        free_word = -40'sd100;
        hist_word = 40'h0A_BCDE_F012;
        loop_word = 40'h55_0000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        settle();
        chk("R1 reset state", TW'(state_o), 0);
        chk("R1 reset tune", tune_o, NOM - 40'd100);
        chk("R1 reset phase flag", TW'(lopl_o), 1);
        chk("R1 reset freq flag", TW'(lofl_o), 1);
        ticks(3);
        chk("R1 free-run without reference", TW'(state_o), 0);

        // R2: free-run to acquisition
        ref_avail = 1; plock = 1; flock = 1;
        ticks(1);
        settle();
        chk("R2 to acquisition", TW'(state_o), 1);
        chk("R10 live word", tune_o, loop_word);

        // R3: a dropped lock indication restarts qualification
        ticks(3);
        plock = 0; ticks(1);
        plock = 1; ticks(4);
        settle();
        chk("R3 still acquiring", TW'(state_o), 1);
        ticks(1);
        settle();
        chk("R3 locked after run", TW'(state_o), 2);
        chk("R7 phase flag clear", TW'(lopl_o), 0);
        chk("R8 freq flag clear", TW'(lofl_o), 0);

        // R8: flag follows the raw frequency lock while locked
        flock = 0; ticks(1);
        settle();
        chk("R8 freq flag raised", TW'(lofl_o), 1);
        flock = 1; ticks(1);

        // R11: losing phase lock returns to acquisition
        plock = 0; ticks(1);
        settle();
        chk("R11 back to acquisition", TW'(state_o), 1);
        plock = 1; ticks(LQ);
        chk("R11 relocked", TW'(state_o), 2);

        // R4 / R5: holdover entry with valid history
        hist_en = 1; hist_valid = 1; h1 = hist_word;
        ref_lost = 1; ref_avail = 0; ticks(1);
        settle();
        chk("R4 holdover entered", TW'(state_o), 3);
        chk("R5 history word", tune_o, h1);
        chk("R5 history source", TW'(src_o), 1);
        chk("R7 phase flag in holdover", TW'(lopl_o), 1);

        // R6 / R8: inputs move during holdover
        hist_valid = 0; hist_word = 40'hFF_0000_0001; free_word = 40'd7; flock = 0;
        ticks(3);
        settle();
        chk("R6 word unchanged", tune_o, h1);
        chk("R8 freq flag frozen", TW'(lofl_o), 0);

        // R9: exit with preset
        ref_lost = 0; ref_avail = 1;
        settle();
        chk("R9 preset on exit", TW'(preset_o), 1);
        chk("R9 preset word", tune_o, h1);
        ticks(1);
        settle();
        chk("R9 acquiring after exit", TW'(state_o), 1);
        chk("R9 preset released", TW'(preset_o), 0);
        chk("R8 freq flag updated", TW'(lofl_o), 1);
        flock = 1;

        // R5: history enabled but invalid uses the free-run word
        ticks(LQ);
        hist_en = 1; hist_valid = 0; free_word = -40'sd3;
        ref_lost = 1; ref_avail = 0; ticks(1);
        settle();
        chk("R5 invalid history uses free word", tune_o, NOM - 40'd3);
        chk("R5 free source", TW'(src_o), 0);
        ref_lost = 0; ref_avail = 1; ticks(1);

        // R5: history disabled but valid uses the free-run word
        ticks(LQ);
        hist_en = 0; hist_valid = 1; free_word = 40'd9;
        ref_lost = 1; ref_avail = 0; ticks(1);
        settle();
        chk("R5 disabled history uses free word", tune_o, NOM + 40'd9);
        ref_lost = 0; ref_avail = 1; ticks(1);

        // R4: reference switch while locked restarts acquisition
        ticks(LQ);
        chk("R4 locked before switch", TW'(state_o), 2);
        ref_lost = 1; ref_avail = 1; ticks(1);
        settle();
        chk("R4 switch to acquisition", TW'(state_o), 1);
        // R4: holdover straight from acquisition
        ref_lost = 1; ref_avail = 0; ticks(1);
        settle();
        chk("R4 holdover from acquisition", TW'(state_o), 3);
        ref_lost = 0; ref_avail = 1; ticks(2);

        // pseudo-random phase against the model
        lf = 32'hACE1_2468;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            plock      = (lf[3:0] != 0);
            ref_lost   = (lf[8:4] == 0);
            ref_avail  = (lf[11:10] != 0);
            hist_en    = lf[16];
            hist_valid = lf[17];
            flock      = (lf[20:19] != 0);
            hist_word  = {lf[7:0], lf};
            free_word  = {{8{lf[31]}}, lf[31:0]};
            loop_word  = {lf, lf[15:8]};
            tick();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule